// File: doc/BRIEF.md
# LED Matrix Row-Scan Refresh Controller

This block keeps a seven-row, ninety-six-column LED matrix lit by scanning it one row at a time from a small internal frame store. Each row owns a fixed time slot. The slot opens with every row driver off. During this blanked stretch the controller sends the row's ninety-six column bits as a serial stream with its own divided clock into an external chain of serial-to-parallel shift registers. For the rest of the slot it switches on the single driver of the row it has just loaded. The rows are visited in order from the first to the seventh, and then the frame starts again.

Software or a character generator writes whole row words into the frame store at any moment. A word is picked up when the scan next opens that row's slot, so a row never shows a mix of old and new bits. The lengths of the slot and the serial clock are parameters counted in system clock cycles. The shift phase lasts for one idle cycle followed by two serial-clock half periods per column. The default slot is three times as long as the shift phase, so a row is lit for about two thirds of its slot.

Top module: `ledscan_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs after that edge are `row_en` = 0, `ser_clk` = 0 and `ser_data` = 0. All frame words are cleared to zero. After release the scan restarts with slot cycle 0 of row index 0.
- R2: Number the cycles after reset release g = 0, 1, 2 and so on. The slot cycle is t = g mod SLOT_CYC, and SE = 1 + 2*SCLK_HALF*COLS. For every t < SE, `row_en` is all zero. At t = 0, `ser_clk` and `ser_data` are also 0.
- R3: For 1 <= t < SE, let k = (t-1) div (2*SCLK_HALF). `ser_data` carries bit COLS-1-k of the current row's word, so the farthest column goes out first and column 0 goes out last.
- R4: For 1 <= t < SE, `ser_clk` is 0 when (t-1) mod (2*SCLK_HALF) < SCLK_HALF and 1 otherwise. This gives exactly COLS rising edges per slot, and `ser_data` never changes while `ser_clk` is high. For t >= SE, `ser_clk` and `ser_data` are 0.
- R5: For SE <= t < SLOT_CYC, `row_en` is one-hot with bit r set, where r is the row index of the slot. Bit 0 is the first row.
- R6: The row index of slot number s is s mod ROWS. After the last row, the scan returns to row 0 with no gap.
- R7: A write with `wr_en` = 1 stores `wr_data` into the word for `wr_row`. A write to a row index of ROWS or above changes nothing. A word is sampled at the clock edge that starts its row's slot (t = 0), and a write on that same edge is not seen. A write made during a row's slot shows only from the next visit to that row.
- R8: At no cycle is more than one bit of `row_en` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Frame-store write strobe |
| wr_row | input | 3 | Row index of the word being written (0 = first row) |
| wr_data | input | 96 | Column bits of the row, bit i = column i |
| ser_data | output | 1 | Serial column data to the shift-register chain |
| ser_clk | output | 1 | Serial clock to the chain, data is stable around its rising edge |
| row_en | output | 7 | Row driver enables, at most one set, bit i = row i |

## Verification
The assertions watch properties that hold on every cycle. At most one row is ever on. A row can change only by passing through the all-off state. The serial clock is never high while a row is lit. Serial data holds steady while the serial clock is high. Reset forces every output off, the first row lit after reset is row 0, and each newly lit row is the one after the previous row. Only the bench's scenarios can show the values themselves: which column bit goes out on which cycle, the exact cycle of the phase boundaries, and the rule that a word is taken from the frame store only at the start of its slot. The bench covers this with writes that land in the middle of the row being shifted, writes to the unused row index, and a reset in the middle of a slot.

// File: rtl/ledscan_pkg.sv
package ledscan_pkg;
   // Length of the blanked shift phase: one idle cycle, then a full
   // serial clock period per column.
   function automatic int shift_len(input int cols, input int half);
      return 1 + 2 * half * cols;
   endfunction
endpackage

// File: rtl/ledscan_frame_mem.sv
module ledscan_frame_mem #(
   parameter int ROWS = 7,
   parameter int COLS = 96,
   parameter int RW   = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [RW-1:0]   wr_row,
   input  logic [COLS-1:0] wr_data,
   input  logic [RW-1:0]   rd_row,
   output logic [COLS-1:0] rd_data
);
   logic [COLS-1:0] words [ROWS];

   for (genvar i = 0; i < ROWS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (rst)
            words[i] <= '0;
         else if (wr_en && wr_row == RW'(i))
            words[i] <= wr_data;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < ROWS; i++)
         if (rd_row == RW'(i))
            rd_data = words[i];
   end
endmodule

// File: rtl/ledscan_timer.sv
module ledscan_timer #(
   parameter int ROWS      = 7,
   parameter int RW        = 3,
   parameter int SLOT_CYC  = 1155,
   parameter int SHIFT_END = 385,
   parameter int SCLK_HALF = 2
) (
   input  logic          clk,
   input  logic          rst,
   output logic [RW-1:0] row,
   output logic          slot_start,
   output logic          in_shift,
   output logic          lit,
   output logic          sclk_lvl,
   output logic          bit_last
);
   localparam int CW = $clog2(SLOT_CYC);
   localparam int PERIOD = 2 * SCLK_HALF;
   localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(SLOT_CYC - 1);
   localparam logic [CW-1:0] CNT_SE   = CW'(SHIFT_END);
   localparam logic [PW-1:0] PH_LAST  = PW'(PERIOD - 1);
   localparam logic [PW-1:0] PH_HIGH  = PW'(SCLK_HALF);
   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

   logic [CW-1:0] cnt;
   logic [PW-1:0] ph;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
         row <= '0;
         ph  <= '0;
      end else begin
         if (cnt == CNT_LAST) begin
            cnt <= '0;
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
         if (slot_start)
            ph <= '0;
         else if (in_shift)
            ph <= (ph == PH_LAST) ? '0 : ph + 1'b1;
      end
   end

   always_comb begin
      slot_start = (cnt == '0);
      in_shift   = (cnt != '0) && (cnt < CNT_SE);
      lit        = (cnt >= CNT_SE);
      sclk_lvl   = (ph >= PH_HIGH);
      bit_last   = in_shift && (ph == PH_LAST);
   end
endmodule

// File: rtl/ledscan_serializer.sv
module ledscan_serializer #(
   parameter int COLS = 96
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [COLS-1:0] word,
   input  logic            in_shift,
   input  logic            sclk_lvl,
   input  logic            bit_last,
   output logic            ser_data,
   output logic            ser_clk
);
   logic [COLS-1:0] shreg;

   always_ff @(posedge clk) begin
      if (rst) begin
         shreg    <= '0;
         ser_data <= 1'b0;
         ser_clk  <= 1'b0;
      end else begin
         if (load)
            shreg <= word;
         else if (bit_last)
            shreg <= {shreg[COLS-2:0], 1'b0};
         ser_data <= in_shift ? shreg[COLS-1] : 1'b0;
         ser_clk  <= in_shift & sclk_lvl;
      end
   end
endmodule

// File: rtl/ledscan_row_drv.sv
module ledscan_row_drv #(
   parameter int ROWS = 7,
   parameter int RW   = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            lit,
   input  logic [RW-1:0]   row,
   output logic [ROWS-1:0] row_en
);
   for (genvar i = 0; i < ROWS; i++) begin : g_drv
      always_ff @(posedge clk) begin
         if (rst)
            row_en[i] <= 1'b0;
         else
            row_en[i] <= lit && (row == RW'(i));
      end
   end
endmodule

// File: rtl/ledscan_top.sv
module ledscan_top #(
   parameter int ROWS      = 7,
   parameter int COLS      = 96,
   parameter int SCLK_HALF = 2,
   parameter int SLOT_CYC  = 3 * ledscan_pkg::shift_len(96, 2),
   parameter int RW        = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            wr_en,
   input  logic [RW-1:0]   wr_row,
   input  logic [COLS-1:0] wr_data,
   output logic            ser_data,
   output logic            ser_clk,
   output logic [ROWS-1:0] row_en
);
   localparam int SHIFT_END = ledscan_pkg::shift_len(COLS, SCLK_HALF);

   if (ROWS < 2) begin : g_bad_rows
      $error("ledscan_top: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("ledscan_top: COLS must be at least 2");
   end
   if (SCLK_HALF < 1) begin : g_bad_half
      $error("ledscan_top: SCLK_HALF must be at least 1");
   end
   if (SLOT_CYC <= SHIFT_END) begin : g_bad_slot
      $error("ledscan_top: SLOT_CYC must exceed the shift phase");
   end
   if (RW < $clog2(ROWS)) begin : g_bad_rw
      $error("ledscan_top: RW too narrow for ROWS");
   end

   logic [RW-1:0]   cur_row;
   logic [COLS-1:0] cur_word;
   logic            slot_start, in_shift, lit, sclk_lvl, bit_last;

   ledscan_frame_mem #(.ROWS(ROWS), .COLS(COLS), .RW(RW)) u_mem (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_en),
      .wr_row  (wr_row),
      .wr_data (wr_data),
      .rd_row  (cur_row),
      .rd_data (cur_word)
   );

   ledscan_timer #(
      .ROWS(ROWS), .RW(RW), .SLOT_CYC(SLOT_CYC),
      .SHIFT_END(SHIFT_END), .SCLK_HALF(SCLK_HALF)
   ) u_tmr (
      .clk        (clk),
      .rst        (rst),
      .row        (cur_row),
      .slot_start (slot_start),
      .in_shift   (in_shift),
      .lit        (lit),
      .sclk_lvl   (sclk_lvl),
      .bit_last   (bit_last)
   );

   ledscan_serializer #(.COLS(COLS)) u_ser (
      .clk      (clk),
      .rst      (rst),
      .load     (slot_start),
      .word     (cur_word),
      .in_shift (in_shift),
      .sclk_lvl (sclk_lvl),
      .bit_last (bit_last),
      .ser_data (ser_data),
      .ser_clk  (ser_clk)
   );

   ledscan_row_drv #(.ROWS(ROWS), .RW(RW)) u_drv (
      .clk    (clk),
      .rst    (rst),
      .lit    (lit),
      .row    (cur_row),
      .row_en (row_en)
   );
endmodule

// File: rtl/ledscan_chk.sv
module ledscan_chk #(
   parameter int ROWS = 7
) (
   input logic            clk,
   input logic            rst,
   input logic            ser_data,
   input logic            ser_clk,
   input logic [ROWS-1:0] row_en
);
   logic [ROWS-1:0] last_row;
   logic            seen;

   always_ff @(posedge clk) begin
      if (rst) begin
         last_row <= '0;
         seen     <= 1'b0;
      end else if (row_en != '0) begin
         last_row <= row_en;
         seen     <= 1'b1;
      end
   end

   assert_reset_off_R1: assert property (@(posedge clk)
      rst |=> (row_en == '0 && !ser_clk && !ser_data));

   assert_first_row_R1: assert property (@(posedge clk) disable iff (rst)
      (!seen && row_en != '0) |-> row_en == ROWS'(1));

   assert_blank_between_R2: assert property (@(posedge clk) disable iff (rst)
      (row_en != '0 && row_en != $past(row_en)) |-> $past(row_en) == '0);

   assert_data_stable_R4: assert property (@(posedge clk) disable iff (rst)
      ser_clk |-> $stable(ser_data));

   assert_no_clk_lit_R4: assert property (@(posedge clk) disable iff (rst)
      (row_en != '0) |-> !ser_clk);

   assert_row_order_R6: assert property (@(posedge clk) disable iff (rst)
      (seen && row_en != '0 && row_en != last_row)
         |-> row_en == {last_row[ROWS-2:0], last_row[ROWS-1]});

   assert_one_row_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0(row_en));
endmodule

bind ledscan_top ledscan_chk #(.ROWS(ROWS)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ser_data (ser_data),
   .ser_clk  (ser_clk),
   .row_en   (row_en)
);

// File: tb/ledscan_top_tb.sv
`timescale 1ns/1ps
module ledscan_top_tb;
   localparam int ROWS = 7;
   localparam int COLS = 96;
   localparam int HALF = 2;
   localparam int SE   = 1 + 2 * HALF * COLS;
   localparam int SLOT = 3 * SE;
   localparam int RW   = 3;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            wr_en = 1'b0;
   logic [RW-1:0]   wr_row = '0;
   logic [COLS-1:0] wr_data = '0;
   logic            ser_data, ser_clk;
   logic [ROWS-1:0] row_en;

   int checks = 0;
   int errors = 0;
   int edges  = 0;
   bit done   = 0;
   logic [COLS-1:0] shadow [ROWS];
   logic [COLS-1:0] cur_word;

   always #2 clk = ~clk;

   ledscan_top #(.ROWS(ROWS), .COLS(COLS), .SCLK_HALF(HALF), .SLOT_CYC(SLOT)) u_dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
      .ser_data(ser_data), .ser_clk(ser_clk), .row_en(row_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         if (errors < 30)
            $display("FAIL %s at cycle %0d: actual %h expected %h", tag, edges - 1, act, exp);
      end
   endtask

   function automatic logic [ROWS-1:0] exp_rows(input int g);
      int t = g % SLOT;
      int r = (g / SLOT) % ROWS;
      return (t >= SE) ? ROWS'(1) << r : '0;
   endfunction

   function automatic logic exp_clk(input int g);
      int t = g % SLOT;
      if (t < 1 || t >= SE) return 1'b0;
      return ((t - 1) % (2 * HALF)) >= HALF;
   endfunction

   function automatic logic exp_dat(input int g, input logic [COLS-1:0] w);
      int t = g % SLOT;
      if (t < 1 || t >= SE) return 1'b0;
      return w[COLS - 1 - (t - 1) / (2 * HALF)];
   endfunction

   task automatic check_outputs();
      int g = edges - 1;
      int t = g % SLOT;
      if (t < SE) chk("R2 blank row_en", 32'(row_en), 32'(exp_rows(g)));
      else        chk("R5 R6 lit row_en", 32'(row_en), 32'(exp_rows(g)));
      chk("R4 ser_clk", 32'(ser_clk), 32'(exp_clk(g)));
      chk("R3 R7 ser_data", 32'(ser_data), 32'(exp_dat(g, cur_word)));
   endtask

   // One clock: take the slot word, drive a write, clock, then check.
   task automatic step(input bit we, input int row, input logic [COLS-1:0] d);
      if (edges % SLOT == 0) cur_word = shadow[(edges / SLOT) % ROWS];
      wr_en   = we;
      wr_row  = RW'(row);
      wr_data = d;
      if (we && row < ROWS) shadow[row] = d;
      @(posedge clk);
      edges++;
      @(negedge clk);
      check_outputs();
   endtask

   function automatic logic [COLS-1:0] rnd_word();
      return {$urandom(), $urandom(), $urandom()};
   endfunction

   task automatic do_reset(input int n);
      wr_en = 1'b0;
      rst = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
         chk("R1 reset row_en", 32'(row_en), 32'h0);
         chk("R1 reset ser_clk", 32'(ser_clk), 32'h0);
         chk("R1 reset ser_data", 32'(ser_data), 32'h0);
      end
      for (int r = 0; r < ROWS; r++) shadow[r] = '0;
      rst = 1'b0;
      edges = 0;
   endtask

   task automatic run_random(input int n);
      for (int i = 0; i < n; i++) begin
         if ($urandom_range(0, 99) < 2)
            step(1'b1, $urandom_range(0, 7), rnd_word());
         else
            step(1'b0, 0, '0);
      end
   endtask

   initial begin
      void'($urandom(32'h1ed5ca11));
      @(negedge clk);
      do_reset(3);
      // Row 0 is loaded (all zero) at the first edge; the fill below shows for row 0 only in frame 1 (R7).
      step(1'b0, 0, '0);
      step(1'b1, 0, {COLS/2{2'b10}});
      step(1'b1, 1, {{COLS-1{1'b0}}, 1'b1});
      step(1'b1, 2, {1'b1, {COLS-1{1'b0}}});
      step(1'b1, 3, '1);
      step(1'b1, 4, rnd_word());
      step(1'b1, 5, rnd_word());
      step(1'b1, 6, rnd_word());
      step(1'b1, 7, '1);                  // R7: out-of-range row index is dropped
      run_random(2 * ROWS * SLOT);
      // R7: write on the exact load edge of row 3 is not seen until the next visit.
      while (edges % SLOT != 0 || (edges / SLOT) % ROWS != 3) step(1'b0, 0, '0);
      step(1'b1, 3, 96'h0123_4567_89ab_cdef_fedc_ba98);
      for (int i = 0; i < 40; i++) step(1'b0, 0, '0);
      step(1'b1, 3, rnd_word());          // R7: mid-shift write to the row being shifted
      run_random(ROWS * SLOT);
      // R1: reset in the middle of a slot restarts at row 0.
      for (int i = 0; i < SLOT / 2; i++) step(1'b0, 0, '0);
      do_reset(2);
      step(1'b1, 0, rnd_word());
      run_random(2 * ROWS * SLOT);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule